// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block copies a contiguous run of general-purpose byte registers to or from a byte-addressed memory, one byte per cycle. A caller raises a one-cycle start strobe together with a direction bit, the number of the last register in the run (`n`) and a 16-bit index value. The run always begins at register 0 and ends at register `n`, so `n+1` bytes move. The memory side begins at the address held in the index, taken modulo the 4096-byte memory size. The block owns the memory port and both register file ports while it runs, and it never writes back to the index.

The controller has three states. IDLE waits for a start. The IDLE to XFER transition is taken on start, and the direction, `n` and the low index bits are latched at that point. XFER moves one byte per cycle and stays in XFER while the transfer counter is below `n`. The XFER to DONE transition is taken in the cycle that handles register `n`. DONE lasts one cycle, pulses `done_o` and returns unconditionally to IDLE. In store mode the register file is read combinationally and the memory is written in the same cycle. In load mode the memory returns read data one cycle after the address. Each register write therefore trails its address by one cycle, and the last register write falls in the DONE cycle.

Top module: `blkx_seq`

## Requirements
- R1: While reset is held and afterwards with no start, `busy_o`, `done_o`, `mem_we_o` and `rf_we_o` are all 0.
- R2: With direction 0 (store), register Vk is written to memory address (I+k) mod 4096 for k = 0..n. There is one write per cycle, in consecutive cycles with ascending addresses, and the first write is in the cycle after start.
- R3: With direction 1 (load), the memory byte at (I+k) mod 4096 is written into register Vk for k = 0..n. The register write for byte k occurs one cycle after its address is presented, starting with V0.
- R4: Exactly n+1 bytes are moved, including register n. Registers above n and memory bytes outside I..I+n are never written.
- R5: The first address is bits 11:0 of the index. Index bits 15:12 are ignored, and addresses wrap from 0xFFF to 0x000.
- R6: `busy_o` is 1 from the cycle after an accepted start through the cycle in which `done_o` is 1. `done_o` is a one-cycle pulse, seen n+2 cycles after the start edge, and the block is idle in the following cycle.
- R7: A start raised while `busy_o` is 1, including during the DONE cycle, is ignored and does not restart or extend the operation.
- R8: Direction, n and index are sampled only when start is accepted. Changing them during an operation has no effect.
- R9: Store mode never asserts `rf_we_o`, and load mode never asserts `mem_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| dir_i | input | 1 | 0 = registers to memory, 1 = memory to registers |
| last_reg_i | input | 4 | Number n of the last register in the run |
| index_i | input | 16 | Index value giving the first memory address |
| mem_addr_o | output | 12 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the address |
| rf_rd_sel_o | output | 4 | Register file read select |
| rf_rd_data_i | input | 8 | Register file read data, combinational |
| rf_we_o | output | 1 | Register file write enable |
| rf_wr_sel_o | output | 4 | Register file write select |
| rf_wdata_o | output | 8 | Register file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
In load mode, issuing the address for byte k+1 and writing register k back always fall in the same cycle. The bench provokes this with runs of 1, 4 and 16 bytes, including one that crosses the top of memory. It judges the result by reading the whole register file model afterwards, checking that each Vk holds the byte from its own address and not its neighbour's. The second collision is a new start arriving while an operation is in XFER or DONE. That is judged by the unchanged cycle count to `done_o`, the unchanged write counts, and an idle block in the cycle after DONE.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } blkx_state_e;

    typedef enum logic {
        DIR_STORE = 1'b0,
        DIR_LOAD  = 1'b1
    } blkx_dir_e;

endpackage

// File: rtl/blkx_fsm.sv
module blkx_fsm
    import blkx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] last_i,
    output blkx_state_e      state_o,
    output blkx_dir_e        dir_o,
    output logic [CNT_W-1:0] count_o,
    output logic             accept_o,
    output logic             xfer_o
);

    blkx_state_e      state_q, state_d;
    blkx_dir_e        dir_q;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] count_q;
    logic             final_step;

    assign final_step = (count_q == last_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)    state_d = ST_XFER;
            ST_XFER: if (final_step) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // operation context, captured only on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= DIR_STORE;
            last_q  <= '0;
            count_q <= '0;
        end else if (accept_o) begin
            dir_q   <= blkx_dir_e'(dir_i);
            last_q  <= last_i;
            count_q <= '0;
        end else if (xfer_o && !final_step) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        xfer_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start_i;
            ST_XFER: xfer_o   = 1'b1;
            ST_DONE: ;
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign dir_o   = dir_q;
    assign count_o = count_q;

endmodule

// File: rtl/blkx_agen.sv
module blkx_agen #(
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [IDX_W-1:0]  index_i,
    input  logic [CNT_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base_q;
    logic              unused_index_hi;

    generate
        if (IDX_W > ADDR_W) begin : g_hi
            assign unused_index_hi = ^index_i[IDX_W-1:ADDR_W];
        end else begin : g_nohi
            assign unused_index_hi = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (capture_i) begin
            base_q <= index_i[ADDR_W-1:0];
        end
    end

    // modulo memory size by plain width truncation
    assign addr_o = base_q + ADDR_W'(offset_i);

endmodule

// File: rtl/blkx_ldpipe.sv
module blkx_ldpipe #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [CNT_W-1:0] sel_i,
    output logic             wr_o,
    output logic [CNT_W-1:0] wr_sel_o
);

    logic             pend_q;
    logic [CNT_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            pend_q <= issue_i;
            if (issue_i) begin
                sel_q <= sel_i;
            end
        end
    end

    assign wr_o     = pend_q;
    assign wr_sel_o = sel_q;

endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
    import blkx_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 16,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    localparam int CNT_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [CNT_W-1:0]  last_reg_i,
    input  logic [IDX_W-1:0]  index_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [CNT_W-1:0]  rf_rd_sel_o,
    input  logic [DATA_W-1:0] rf_rd_data_i,
    output logic              rf_we_o,
    output logic [CNT_W-1:0]  rf_wr_sel_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              busy_o,
    output logic              done_o
);

    blkx_state_e      state;
    blkx_dir_e        dir;
    logic [CNT_W-1:0] count;
    logic             accept;
    logic             xfer;
    logic             ld_issue;
    logic             ld_wr;
    logic [CNT_W-1:0] ld_sel;
    logic [ADDR_W-1:0] addr;

    blkx_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .dir_i    (dir_i),
        .last_i   (last_reg_i),
        .state_o  (state),
        .dir_o    (dir),
        .count_o  (count),
        .accept_o (accept),
        .xfer_o   (xfer)
    );

    blkx_agen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (accept),
        .index_i   (index_i),
        .offset_i  (count),
        .addr_o    (addr)
    );

    assign ld_issue = xfer && (dir == DIR_LOAD);

    blkx_ldpipe #(.CNT_W(CNT_W)) i_ldpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (ld_issue),
        .sel_i    (count),
        .wr_o     (ld_wr),
        .wr_sel_o (ld_sel)
    );

    // output decode
    always_comb begin
        mem_addr_o  = addr;
        mem_wdata_o = rf_rd_data_i;
        mem_we_o    = 1'b0;
        rf_rd_sel_o = count;
        rf_we_o     = ld_wr;
        rf_wr_sel_o = ld_sel;
        rf_wdata_o  = mem_rdata_i;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                busy_o   = 1'b1;
                mem_we_o = (dir == DIR_STORE);
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              rf_we_o,
    input logic [CNT_W-1:0]  rf_wr_sel_o
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_we_o && !rf_we_o));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    p_first_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_we_o) |-> (rf_wr_sel_o == '0));

    p_reg_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && $past(rf_we_o)) |-> (rf_wr_sel_o == $past(rf_wr_sel_o) + CNT_W'(1)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_run_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_dir_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && rf_we_o));

endmodule

bind blkx_seq blkx_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_blkx_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .rf_we_o     (rf_we_o),
    .rf_wr_sel_o (rf_wr_sel_o)
);

// File: tb/test_blkx_seq.sv
module test_blkx_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [3:0]  last_reg_i = '0;
    logic [15:0] index_i = '0;
    logic [11:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [7:0]  mem_rdata_i;
    logic [3:0]  rf_rd_sel_o;
    logic [7:0]  rf_rd_data_i;
    logic        rf_we_o;
    logic [3:0]  rf_wr_sel_o;
    logic [7:0]  rf_wdata_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int mem_wr_cnt = 0;
    int rf_wr_cnt = 0;
    int bad_sel = 0;
    int cur_n = 0;

    logic [7:0] mem [4096];
    logic [7:0] regs [16];

    always #5 clk = ~clk;

    blkx_seq i_blkx_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .last_reg_i(last_reg_i), .index_i(index_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .mem_rdata_i(mem_rdata_i), .rf_rd_sel_o(rf_rd_sel_o),
        .rf_rd_data_i(rf_rd_data_i), .rf_we_o(rf_we_o),
        .rf_wr_sel_o(rf_wr_sel_o), .rf_wdata_o(rf_wdata_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // memory and register file models
    assign rf_rd_data_i = regs[rf_rd_sel_o];
    always @(posedge clk) begin
        mem_rdata_i <= mem[mem_addr_o];
        if (mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            mem_wr_cnt = mem_wr_cnt + 1;
        end
        if (rf_we_o) begin
            regs[rf_wr_sel_o] <= rf_wdata_o;
            rf_wr_cnt = rf_wr_cnt + 1;
            if (int'(rf_wr_sel_o) > cur_n) bad_sel = bad_sel + 1;
        end
    end

    function automatic logic [7:0] mem_pat(input int a, input int s);
        return 8'((a ^ (a >> 4)) + s * 13 + 1);
    endfunction

    function automatic logic [7:0] reg_pat(input int k, input int s);
        return 8'(8'hA0 + k * 3 + s * 7);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input int s);
        for (int a = 0; a < 4096; a++) mem[a] = mem_pat(a, s);
        for (int k = 0; k < 16; k++) regs[k] = reg_pat(k, s);
    endtask

    // one operation; optional intrusive start after 'poke' samples (0 = none)
    task automatic run(input bit dir, input int n, input logic [15:0] idx,
                       input int s, input int poke);
        int cnt;
        int busy_bad;
        int base;
        fill(s);
        base = int'(idx[11:0]);
        @(negedge clk);
        mem_wr_cnt = 0; rf_wr_cnt = 0; bad_sel = 0; cur_n = n;
        start_i = 1'b1; dir_i = dir; last_reg_i = 4'(n); index_i = idx;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        // R8: scramble the operands while the operation runs
        dir_i = ~dir; last_reg_i = ~4'(n); index_i = idx ^ 16'h5A5A;
        cnt = 1;
        busy_bad = 0;
        while (!done_o && cnt < 40) begin
            if (!busy_o) busy_bad++;
            start_i = (poke != 0 && cnt == poke);
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        // R7: also raise start during the DONE cycle when poking
        start_i = (poke != 0);
        chk(busy_bad == 0, "R6 busy during run", busy_bad, 0);
        chk(cnt == n + 2, "R6 cycles to done", cnt, n + 2);
        chk(busy_o == 1'b1, "R6 busy with done", int'(busy_o), 1);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && !done_o, "R7 idle after done", int'({busy_o, done_o}), 0);
        if (!dir) begin
            for (int k = 0; k <= n; k++) begin
                int a = (base + k) % 4096;
                chk(mem[a] == reg_pat(k, s), "R2 stored byte", int'(mem[a]), int'(reg_pat(k, s)));
            end
            chk(mem[(base + n + 1) % 4096] == mem_pat((base + n + 1) % 4096, s),
                "R4 byte past run", int'(mem[(base + n + 1) % 4096]),
                int'(mem_pat((base + n + 1) % 4096, s)));
            chk(mem[(base + 4095) % 4096] == mem_pat((base + 4095) % 4096, s),
                "R5 byte before run", int'(mem[(base + 4095) % 4096]),
                int'(mem_pat((base + 4095) % 4096, s)));
            chk(mem_wr_cnt == n + 1, "R4 store count", mem_wr_cnt, n + 1);
            chk(rf_wr_cnt == 0, "R9 no reg writes in store", rf_wr_cnt, 0);
        end else begin
            for (int k = 0; k < 16; k++) begin
                logic [7:0] e;
                e = (k <= n) ? mem_pat((base + k) % 4096, s) : reg_pat(k, s);
                chk(regs[k] == e, (k <= n) ? "R3 loaded reg" : "R4 reg above n",
                    int'(regs[k]), int'(e));
            end
            chk(rf_wr_cnt == n + 1, "R4 load count", rf_wr_cnt, n + 1);
            chk(bad_sel == 0, "R4 select above n", bad_sel, 0);
            chk(mem_wr_cnt == 0, "R9 no mem writes in load", mem_wr_cnt, 0);
        end
    endtask

    // {dir, n, index}
    localparam logic [20:0] VECS [8] = '{
        {1'b0, 4'd2,  16'h0200},
        {1'b1, 4'd2,  16'h0300},
        {1'b0, 4'd0,  16'h0010},
        {1'b1, 4'd0,  16'h0011},
        {1'b0, 4'd15, 16'h0400},
        {1'b1, 4'd15, 16'h0500},
        {1'b0, 4'd3,  16'h0FFE},
        {1'b1, 4'd3,  16'hAFFD}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        fill(0);
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, mem_we_o, rf_we_o} == 4'b0, "R1 in reset",
            int'({busy_o, done_o, mem_we_o, rf_we_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, mem_we_o, rf_we_o} == 4'b0, "R1 idle after reset",
            int'({busy_o, done_o, mem_we_o, rf_we_o}), 0);

        // table walk: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < 8; i++) begin
            run(VECS[i][20], int'(VECS[i][19:16]), VECS[i][15:0], i + 1, 0);
        end

        // R7: start raised during XFER and during DONE
        run(1'b0, 5, 16'h0700, 11, 2);
        run(1'b1, 6, 16'h0FFC, 12, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule